// File: doc/BRIEF.md
# Dual Event Counter Unit

This block counts hardware events in two 32-bit counters that share one control register. Each counter has its own event selector, which picks a group of eight event strobes and a mask within that group. Every cycle, the strobes arrive together with a tag giving the privilege level of the code that is running. Three count enables, one for each privilege level, apply to both counters at once. Because of this, a counter cannot be stopped by itself. Software parks an unused counter by pointing it at a placeholder event that almost never fires.

Both counters are read and written through one 64-bit counter register. Software can preload a counter with a negated period, so that it wraps after a chosen number of events. A wrap from all ones to zero sets a sticky flag. Each counter has a trap enable, and a flag whose trap enable is set drives a level interrupt. Any write to the control register acknowledges the interrupt, even a write of the same value.

Top module: `dual_event_counter`

## Requirements
- R1: After reset, both counters read 0, the control register reads 0 and `ovf_irq` is low.
- R2: Address 1 is the counter register, with the upper counter in bits 63:32 and the lower counter in bits 31:0. A write updates only the halves whose `reg_wmask` bit is set (bit 0 selects the lower half, bit 1 the upper half). A write with a zero mask changes nothing.
- R3: When a counter holding 0xFFFFFFFF increments, it becomes 0 and its sticky flag is set. The flag reads back at control bit 18 for the lower counter and at control bit 31 for the upper counter. The flag stays set until the next control write.
- R4: Address 0 is the control register, with this layout: bit 1 supervisor enable, bit 2 user enable, bit 3 hypervisor enable, bit 4 lower trap enable, bit 5 upper trap enable, bits 17:6 lower event code, bits 30:19 upper event code. Bit 0 always reads 0. Values written to bits 31 and 18 are ignored. Bits 63:32 read 0.
- R5: In an event code, bits 11:8 pick group g (strobes 8g to 8g+7) and bits 7:0 are a mask over that group. A counter adds exactly 1 in a cycle when any masked strobe is high and the privilege level is enabled. A group number at or above `GROUP_COUNT` never counts.
- R6: `cur_priv` is encoded as 0 user, 1 supervisor, 2 hypervisor and 3 none. A cycle counts only if the matching enable bit is set, and the enables act on both counters. Level 3 never counts. With all three enables clear, neither counter moves.
- R7: Event code 0x220 counts only strobe 21; no other strobe affects it.
- R8: `ovf_irq` is high while any counter's flag and that counter's trap enable are both set. A flag whose trap enable is clear leaves `ovf_irq` low.
- R9: Any control write clears both flags, including a write of the unchanged value. A wrap in the same cycle as a control write still leaves its flag set.
- R10: If a counter write and an increment of the same half happen in the same cycle, the written value is kept and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control register, 1 selects the counter register |
| reg_wmask | input | 2 | Half enables for counter writes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` |
| cur_priv | input | 2 | Privilege tag of this cycle's strobes |
| evt_strobe | input | GROUP_COUNT*8 | Event strobes |
| ovf_irq | output | 1 | Overflow interrupt level |

## Verification
The counting function is driven with three kinds of pattern. Single-strobe patterns show whether the right group and mask are decoded. Patterns with all strobes high except one expose a selector that leaks across groups or that ignores the placeholder's single strobe. Sweeps over all four privilege tags under each enable setting show whether the shared gating is wrong. Preloads just below the wrap point are combined with control and counter writes in the same cycle, which separates the wrap flag, the acknowledge and write priority from one another. A long pseudo-random mix of writes, strobes and privilege tags runs against a behavioural model and compares the result every cycle.

// File: rtl/dec_pkg.sv
package dec_pkg;

    localparam int CNT_W     = 32;
    localparam int EV_W      = 12;
    localparam int GRP_SEL_W = 4;
    localparam int GRP_W     = 8;

    typedef enum logic [1:0] {
        PRIV_USR  = 2'd0,
        PRIV_SUP  = 2'd1,
        PRIV_HV   = 2'd2,
        PRIV_NONE = 2'd3
    } priv_e;

    // Control register layout, MSB first
    typedef struct packed {
        logic            ovf_hi;   // 31
        logic [EV_W-1:0] ev_hi;    // 30:19
        logic            ovf_lo;   // 18
        logic [EV_W-1:0] ev_lo;    // 17:6
        logic            trap_hi;  // 5
        logic            trap_lo;  // 4
        logic            en_hv;    // 3
        logic            en_usr;   // 2
        logic            en_sup;   // 1
        logic            rsvd;     // 0
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } lane_t;

endpackage

// File: rtl/dec_evt_match.sv
module dec_evt_match
    import dec_pkg::*;
#(
    parameter int GROUP_COUNT = 12,
    parameter int STROBE_W    = GROUP_COUNT * GRP_W
) (
    input  logic [STROBE_W-1:0] strobe_i,
    input  logic [EV_W-1:0]     code_i,
    input  logic                gate_i,
    output logic                hit_o
);

    logic [GRP_SEL_W-1:0] grp;
    logic [GRP_W-1:0]     mask;
    logic [GRP_W-1:0]     sel;

    always_comb begin
        grp  = code_i[EV_W-1 -: GRP_SEL_W];
        mask = code_i[GRP_W-1:0];
        sel  = '0;
        for (int g = 0; g < GROUP_COUNT; g++) begin
            if (grp == g[GRP_SEL_W-1:0]) begin
                sel = strobe_i[g*GRP_W +: GRP_W];
            end
        end
        hit_o = gate_i & (|(sel & mask));
    end

endmodule

// File: rtl/dec_cnt_lane.sv
module dec_cnt_lane
    import dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] ONE = 1;

    lane_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        wrap_o = 1'b0;
        if (wr_i) begin
            st_d.cnt = wdata_i;
        end else if (inc_i) begin
            st_d.cnt = st_q.cnt + ONE;
            wrap_o   = &st_q.cnt;
        end
        st_d.ovf = (st_q.ovf & ~clr_i) | wrap_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;

    p_wrap_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !wr_i && (&st_q.cnt)) |=> (st_q.ovf && st_q.cnt == '0));

    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !clr_i) |=> st_q.ovf);

    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (st_q.cnt == $past(wdata_i)));

    p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !wr_i) |=> (st_q.cnt == $past(st_q.cnt) + ONE));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !wr_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/dual_event_counter.sv
module dual_event_counter
    import dec_pkg::*;
#(
    parameter int GROUP_COUNT = 12,
    localparam int STROBE_W   = GROUP_COUNT * GRP_W,
    localparam int REG_W      = 2 * CNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wen,
    input  logic                reg_addr,
    input  logic [1:0]          reg_wmask,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [1:0]          cur_priv,
    input  logic [STROBE_W-1:0] evt_strobe,
    output logic                ovf_irq
);

    localparam int    LANES     = 2;
    localparam int    CTRL_W    = $bits(ctrl_t);
    localparam logic  ADDR_CTRL = 1'b0;
    localparam logic  ADDR_CNT  = 1'b1;

    ctrl_t ctrl_q, ctrl_d;
    ctrl_t ctrl_view;

    logic                 ctrl_wr;
    logic                 priv_ok;
    logic [LANES-1:0]     cnt_wr;
    logic [LANES-1:0]     hit;
    logic [LANES-1:0]     ovf;
    logic [LANES-1:0]     wrap;
    logic [CNT_W-1:0]     cnt [LANES];

    assign ctrl_wr = reg_wen && (reg_addr == ADDR_CTRL);

    always_comb begin
        case (priv_e'(cur_priv))
            PRIV_USR: priv_ok = ctrl_q.en_usr;
            PRIV_SUP: priv_ok = ctrl_q.en_sup;
            PRIV_HV:  priv_ok = ctrl_q.en_hv;
            default:  priv_ok = 1'b0;
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [EV_W-1:0] code;

        if (i == 0) begin : g_lo
            assign code = ctrl_q.ev_lo;
        end else begin : g_hi
            assign code = ctrl_q.ev_hi;
        end

        assign cnt_wr[i] = reg_wen && (reg_addr == ADDR_CNT) && reg_wmask[i];

        dec_evt_match #(
            .GROUP_COUNT(GROUP_COUNT),
            .STROBE_W   (STROBE_W)
        ) u_match (
            .strobe_i(evt_strobe),
            .code_i  (code),
            .gate_i  (priv_ok),
            .hit_o   (hit[i])
        );

        dec_cnt_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc_i  (hit[i]),
            .wr_i   (cnt_wr[i]),
            .wdata_i(reg_wdata[i*CNT_W +: CNT_W]),
            .clr_i  (ctrl_wr),
            .cnt_o  (cnt[i]),
            .ovf_o  (ovf[i]),
            .wrap_o (wrap[i])
        );
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d        = ctrl_t'(reg_wdata[CTRL_W-1:0]);
            ctrl_d.ovf_hi = 1'b0;
            ctrl_d.ovf_lo = 1'b0;
            ctrl_d.rsvd   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        ctrl_view        = ctrl_q;
        ctrl_view.ovf_lo = ovf[0];
        ctrl_view.ovf_hi = ovf[1];
        if (reg_addr == ADDR_CNT) begin
            reg_rdata = {cnt[1], cnt[0]};
        end else begin
            reg_rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl_view};
        end
    end

    assign ovf_irq = (ovf[0] & ctrl_q.trap_lo) | (ovf[1] & ctrl_q.trap_hi);

    p_ack_clears_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wrap == '0) |=> !ovf_irq);

    p_wrap_raises_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((wrap[0] && ctrl_d.trap_lo) || (wrap[1] && ctrl_d.trap_hi)) |=> ovf_irq);

    p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_irq && !ctrl_wr) |=> ovf_irq);

    p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ctrl_q.en_usr || ctrl_q.en_sup || ctrl_q.en_hv) && cnt_wr == '0)
        |=> ($stable(cnt[0]) && $stable(cnt[1])));

    p_priv_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_priv == PRIV_NONE && cnt_wr == '0)
        |=> ($stable(cnt[0]) && $stable(cnt[1])));

endmodule

// File: tb/test_dual_event_counter.sv
module test_dual_event_counter;

    localparam int GROUPS = 12;
    localparam int SW     = GROUPS * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          t_wen = 1'b0;
    logic          t_addr = 1'b0;
    logic [1:0]    t_wmask = 2'b00;
    logic [63:0]   t_wdata = '0;
    logic [1:0]    t_priv = 2'd3;
    logic [SW-1:0] t_strobe = '0;
    logic [63:0]   rdata;
    logic          irq;

    int vectors = 0;
    int fails   = 0;

    // reference model state
    logic [31:0] m_cnt [2];
    logic        m_ovf [2];
    logic [31:0] m_ctrl;
    logic [31:0] rng = 32'h1d2c_3b4a;

    always #5 clk = ~clk;

    dual_event_counter #(.GROUP_COUNT(GROUPS)) i_dual_event_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wen   (t_wen),
        .reg_addr  (t_addr),
        .reg_wmask (t_wmask),
        .reg_wdata (t_wdata),
        .reg_rdata (rdata),
        .cur_priv  (t_priv),
        .evt_strobe(t_strobe),
        .ovf_irq   (irq)
    );

    function automatic logic [31:0] rnd();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    function automatic logic m_hit(int lane);
        logic [11:0] code;
        int          grp;
        logic        ok;
        code = (lane == 1) ? m_ctrl[30:19] : m_ctrl[17:6];
        grp  = int'(code[11:8]);
        ok   = (t_priv == 2'd0 && m_ctrl[2]) || (t_priv == 2'd1 && m_ctrl[1]) ||
               (t_priv == 2'd2 && m_ctrl[3]);
        if (grp >= GROUPS) return 1'b0;
        return ok && ((t_strobe[grp*8 +: 8] & code[7:0]) != 8'h00);
    endfunction

    function automatic logic [63:0] m_read(logic a);
        logic [31:0] c;
        c = m_ctrl;
        c[31] = m_ovf[1];
        c[18] = m_ovf[0];
        return a ? {m_cnt[1], m_cnt[0]} : {32'h0, c};
    endfunction

    function automatic logic m_irq();
        return (m_ovf[0] && m_ctrl[4]) || (m_ovf[1] && m_ctrl[5]);
    endfunction

    task automatic model_advance();
        logic h [2];
        logic wrp [2];
        logic cw;
        for (int i = 0; i < 2; i++) h[i] = m_hit(i);
        cw = t_wen && !t_addr;
        for (int i = 0; i < 2; i++) begin
            wrp[i] = 1'b0;
            if (t_wen && t_addr && t_wmask[i]) begin
                m_cnt[i] = t_wdata[i*32 +: 32];
            end else if (h[i]) begin
                wrp[i]   = (m_cnt[i] == 32'hFFFF_FFFF);
                m_cnt[i] = m_cnt[i] + 32'd1;
            end
        end
        if (cw) m_ctrl = t_wdata[31:0] & 32'h7FFB_FFFE;
        for (int i = 0; i < 2; i++) m_ovf[i] = (cw ? 1'b0 : m_ovf[i]) | wrp[i];
    endtask

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: apply driven inputs, advance model, compare at next negedge
    task automatic step(string tag);
        model_advance();
        @(posedge clk);
        @(negedge clk);
        chk(tag, rdata, m_read(t_addr));
        chk(tag, {63'h0, irq}, {63'h0, m_irq()});
    endtask

    task automatic set_idle();
        t_wen    = 1'b0;
        t_wmask  = 2'b00;
        t_priv   = 2'd3;
        t_strobe = '0;
    endtask

    task automatic wr_ctrl(logic [31:0] v, string tag);
        set_idle();
        t_wen   = 1'b1;
        t_addr  = 1'b0;
        t_wdata = {32'h0, v};
        step(tag);
        t_wen   = 1'b0;
    endtask

    task automatic wr_cnt(logic [1:0] m, logic [63:0] v, string tag);
        set_idle();
        t_wen   = 1'b1;
        t_addr  = 1'b1;
        t_wmask = m;
        t_wdata = v;
        step(tag);
        set_idle();
    endtask

    task automatic pulse(logic [1:0] p, logic [SW-1:0] s, int n, string tag);
        set_idle();
        t_addr   = 1'b1;
        t_priv   = p;
        t_strobe = s;
        for (int k = 0; k < n; k++) step(tag);
        set_idle();
    endtask

    task automatic peek(logic a, string tag, output logic [63:0] v);
        set_idle();
        t_addr = a;
        step(tag);
        v = rdata;
    endtask

    logic [SW-1:0] rnd_strobe;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : main
        logic [63:0] v, cap;
        for (int i = 0; i < 2; i++) begin
            m_cnt[i] = '0;
            m_ovf[i] = 1'b0;
        end
        m_ctrl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(1'b0, "R1", v); chk("R1", v, 64'h0);
        chk("R1", {63'h0, irq}, 64'h0);
        peek(1'b1, "R1", v); chk("R1", v, 64'h0);

        // R4 layout and ignored bits
        wr_ctrl(32'h8814_007F, "R4");
        peek(1'b0, "R4", v); chk("R4", v, 64'h0810_007E);

        // R5 group/mask decode
        pulse(2'd0, 96'h1, 5, "R5");
        pulse(2'd0, 96'h201, 3, "R5");
        pulse(2'd0, 96'h100, 2, "R5");
        peek(1'b1, "R5", v); chk("R5", v, {32'd3, 32'd8});
        for (int k = 0; k < 300; k++) begin
            rnd_strobe = {rnd(), rnd(), rnd()} & {rnd(), rnd(), rnd()};
            pulse(rnd() % 4, rnd_strobe, 1, "R5");
        end

        // R6 privilege gating
        peek(1'b1, "R6", cap);
        wr_ctrl(32'h0810_0044, "R6");
        pulse(2'd1, 96'h201, 1, "R6");
        pulse(2'd2, 96'h201, 1, "R6");
        pulse(2'd3, 96'h201, 1, "R6");
        peek(1'b1, "R6", v); chk("R6", v, cap);
        pulse(2'd0, 96'h201, 1, "R6");
        peek(1'b1, "R6", v); chk("R6", v, cap + 64'h0000_0001_0000_0001);
        wr_ctrl(32'h0810_0042, "R6");
        pulse(2'd0, 96'h201, 1, "R6");
        pulse(2'd1, 96'h201, 1, "R6");
        peek(1'b1, "R6", v); chk("R6", v, cap + 64'h0000_0002_0000_0002);
        wr_ctrl(32'h0810_0040, "R6");
        for (int p = 0; p < 4; p++) pulse(p[1:0], '1, 1, "R6");
        peek(1'b1, "R6", v); chk("R6", v, cap + 64'h0000_0002_0000_0002);

        // R5 group out of range on lower counter
        peek(1'b1, "R5", cap);
        wr_ctrl(32'h0813_404E, "R5");
        pulse(2'd0, '1, 4, "R5");
        peek(1'b1, "R5", v); chk("R5", v, cap + 64'h0000_0004_0000_0000);

        // R7 placeholder code on upper counter
        peek(1'b1, "R7", cap);
        wr_ctrl(32'h1100_004E, "R7");
        pulse(2'd0, ~96'h20_0000, 4, "R7");
        peek(1'b1, "R7", v); chk("R7", v, cap + 64'h0000_0000_0000_0004);
        pulse(2'd0, 96'h20_0000, 2, "R7");
        peek(1'b1, "R7", v); chk("R7", v, cap + 64'h0000_0002_0000_0004);

        // R2 half writes
        peek(1'b1, "R2", cap);
        wr_cnt(2'b01, 64'hAAAA_BBBB_FFFF_FFFD, "R2");
        peek(1'b1, "R2", v); chk("R2", v, {cap[63:32], 32'hFFFF_FFFD});
        wr_cnt(2'b10, 64'h1234_5678_0000_0000, "R2");
        peek(1'b1, "R2", v); chk("R2", v, 64'h1234_5678_FFFF_FFFD);
        wr_cnt(2'b00, 64'h0, "R2");
        peek(1'b1, "R2", v); chk("R2", v, 64'h1234_5678_FFFF_FFFD);

        // R3 / R8 wrap with trap enabled on the lower counter
        wr_ctrl(32'h0810_005E, "R3");
        wr_cnt(2'b01, 64'hFFFF_FFFE, "R3");
        pulse(2'd0, 96'h1, 1, "R3");
        peek(1'b0, "R3", v); chk("R3", v, 64'h0810_005E);
        chk("R8", {63'h0, irq}, 64'h0);
        pulse(2'd0, 96'h1, 1, "R3");
        peek(1'b0, "R3", v); chk("R3", v, 64'h0814_005E);
        chk("R8", {63'h0, irq}, 64'h1);
        for (int k = 0; k < 5; k++) peek(1'b1, "R8", v);
        chk("R3", v, 64'h1234_5678_0000_0000);
        chk("R8", {63'h0, irq}, 64'h1);

        // R9 same-value rewrite acknowledges
        wr_ctrl(32'h0810_005E, "R9");
        peek(1'b0, "R9", v); chk("R9", v, 64'h0810_005E);
        chk("R9", {63'h0, irq}, 64'h0);

        // R8 flag without trap enable
        wr_ctrl(32'h0810_004E, "R8");
        wr_cnt(2'b10, 64'hFFFF_FFFF_0000_0000, "R8");
        pulse(2'd0, 96'h200, 1, "R8");
        peek(1'b0, "R8", v); chk("R8", v, 64'h8810_004E);
        chk("R8", {63'h0, irq}, 64'h0);
        wr_ctrl(32'h0810_006E, "R9");
        peek(1'b0, "R9", v); chk("R9", v, 64'h0810_006E);
        chk("R9", {63'h0, irq}, 64'h0);

        // R9 wrap coincident with control write
        wr_cnt(2'b10, 64'hFFFF_FFFF_0000_0000, "R9");
        set_idle();
        t_wen = 1'b1; t_addr = 1'b0; t_wdata = 64'h0810_006E;
        t_priv = 2'd0; t_strobe = 96'h200;
        step("R9");
        peek(1'b0, "R9", v); chk("R9", v, 64'h8810_006E);
        chk("R9", {63'h0, irq}, 64'h1);

        // R10 write beats increment
        wr_ctrl(32'h0810_006E, "R10");
        wr_cnt(2'b01, 64'hFFFF_FFFF, "R10");
        set_idle();
        t_wen = 1'b1; t_addr = 1'b1; t_wmask = 2'b01; t_wdata = 64'h100;
        t_priv = 2'd0; t_strobe = 96'h1;
        step("R10");
        peek(1'b0, "R10", v); chk("R10", v, 64'h0810_006E);
        chk("R10", {63'h0, irq}, 64'h0);
        peek(1'b1, "R10", v); chk("R10", v[31:0], 64'h100);

        // mixed pseudo-random traffic against the model
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            r = rnd();
            set_idle();
            t_addr   = r[0];
            t_priv   = r[2:1];
            t_strobe = {rnd(), rnd(), rnd()} & {rnd(), rnd(), rnd()};
            if (r[7:4] == 4'h0) begin
                t_wen   = 1'b1;
                t_addr  = 1'b0;
                t_wdata = {32'h0, rnd()};
            end else if (r[7:4] == 4'h1) begin
                t_wen   = 1'b1;
                t_addr  = 1'b1;
                t_wmask = r[9:8];
                t_wdata = {28'hFFF_FFFF, rnd() & 32'hF, 28'hFFF_FFFF, rnd() & 32'hF};
            end
            step("R3");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule